// File: doc/BRIEF.md
# Second-Level Memory Port Arbiter with Cache Configuration Register

This block sits in front of a shared second-level memory port and decides, every cycle, which of two requestors owns it: the first-level data cache (its misses and write-backs) or the transfer crossbar that carries DMA traffic. Each requestor has its own request and grant wire. A grant is registered. Once a requestor holds the grant, it keeps it for as long as it keeps requesting. The fixed priority that settles a contest is chosen at run time by one bit of a 32-bit configuration register.

The same register carries two write-only invalidate strobes. Writing 1 to either strobe produces a one-cycle pulse toward the program cache or the data cache. The register also holds a 3-bit partition mode that splits a 64 KB second-level array into 16 KB cache ways and directly addressed SRAM. The block decodes the mode into a per-way enable mask, filled from way 0 upward, and into the remaining SRAM size in kilobytes. Software writes the register with a single-cycle write strobe and reads it back combinationally.

Top module: `l2_port_arbiter`

## Requirements
- R1: After reset the register reads 0x00000000, both grants and both invalidate pulses are low, the way mask is 0000 and the SRAM size is 64.
- R2: Register bit 31 is the priority bit. A write stores bit 31 of the write data, and a read returns the stored value in bit 31.
- R3: Bits 30:10 and 7:3 always read 0, whatever value was written to them.
- R4: Bit 9 always reads 0. A write with bit 9 set drives `inv_prog` high for exactly the cycle after the write. A write with bit 9 clear leaves `inv_prog` low.
- R5: Bit 8 always reads 0. A write with bit 8 set drives `inv_data` high for exactly the cycle after the write. A write with bit 8 clear leaves `inv_data` low.
- R6: Bits 2:0 hold the mode. The mode sets the way mask and the SRAM size as follows:
  - 000 gives mask 0000 and 64 KB of SRAM.
  - 001 gives mask 0001 and 48 KB of SRAM.
  - 010 gives mask 0011 and 32 KB of SRAM.
  - 011 gives mask 0111 and 16 KB of SRAM.
  - 111 gives mask 1111 and no SRAM.
- R7: A write carrying mode code 100, 101 or 110 leaves bits 2:0 unchanged. The other fields of that write still take effect.
- R8: At most one grant is high in any cycle. A grant is only high when its requestor was requesting in the previous cycle.
- R9: When the port is free and both requestors ask, the arbiter picks a winner by the priority bit. With priority 0 the data cache wins. With priority 1 the crossbar wins.
- R10: A granted requestor keeps its grant while its request stays high. This holds whatever the other request does and however the priority bit changes meanwhile.
- R11: A request reaching a free port is granted in the next cycle. When the holder drops its request, a waiting requestor is granted in the next cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_wr_en | input | 1 | Register write strobe |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Register read data |
| dc_req | input | 1 | Data-cache request |
| dc_gnt | output | 1 | Data-cache grant |
| xb_req | input | 1 | Crossbar request |
| xb_gnt | output | 1 | Crossbar grant |
| inv_prog | output | 1 | One-cycle program-cache invalidate pulse |
| inv_data | output | 1 | One-cycle data-cache invalidate pulse |
| way_en | output | 4 | Cache-enabled way mask |
| sram_kb | output | 7 | SRAM size in kilobytes |

## Verification
The hardest situation to reach is a priority flip that lands while a requestor already holds the port. To bring it about, both requestors must be active and the register write must fall inside a transfer. The write then must not steal the grant, yet the new priority must decide the very next contest. Directed sequences set this up on purpose: a write during a data-cache transfer, followed by a hand-off to a waiting crossbar request. A long random phase then mixes sticky requests with sparse register writes, including reserved mode codes, and compares every cycle against a bench reference model.

// File: rtl/l2_port_arbiter.sv
module l2_port_arbiter #(
  parameter int WAY_KB   = 16,
  parameter int NUM_WAYS = 4,
  parameter int DATA_W   = 32
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cfg_wr_en,
  input  logic [DATA_W-1:0]   cfg_wdata,
  output logic [DATA_W-1:0]   cfg_rdata,
  input  logic                dc_req,
  output logic                dc_gnt,
  input  logic                xb_req,
  output logic                xb_gnt,
  output logic                inv_prog,
  output logic                inv_data,
  output logic [NUM_WAYS-1:0] way_en,
  output logic [$clog2(NUM_WAYS*WAY_KB+1)-1:0] sram_kb
);
  localparam int PRIO_BIT = DATA_W - 1;
  localparam int IP_BIT   = 9;
  localparam int ID_BIT   = 8;
  localparam int MODE_W   = 3;
  localparam int CNT_W    = $clog2(NUM_WAYS + 1);
  localparam int SRAM_W   = $clog2(NUM_WAYS*WAY_KB + 1);

  typedef enum logic [1:0] {OWN_NONE, OWN_DC, OWN_XB} owner_t;

  logic              prio_q;
  logic [MODE_W-1:0] mode_q;
  logic              inv_prog_q, inv_data_q;
  owner_t            owner_q, owner_d;
  logic [MODE_W-1:0] wr_mode;
  logic              wr_mode_ok;
  logic [CNT_W-1:0]  way_cnt;

  assign wr_mode    = cfg_wdata[MODE_W-1:0];
  assign wr_mode_ok = (wr_mode == 3'b111) || !wr_mode[2];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prio_q     <= 1'b0;
      mode_q     <= '0;
      inv_prog_q <= 1'b0;
      inv_data_q <= 1'b0;
    end else begin
      inv_prog_q <= cfg_wr_en & cfg_wdata[IP_BIT];
      inv_data_q <= cfg_wr_en & cfg_wdata[ID_BIT];
      if (cfg_wr_en) begin
        prio_q <= cfg_wdata[PRIO_BIT];
        if (wr_mode_ok) mode_q <= wr_mode;
      end
    end
  end

  always_comb begin
    cfg_rdata           = '0;
    cfg_rdata[PRIO_BIT] = prio_q;
    cfg_rdata[MODE_W-1:0] = mode_q;
  end

  assign inv_prog = inv_prog_q;
  assign inv_data = inv_data_q;

  always_comb begin
    if (owner_q == OWN_DC && dc_req)      owner_d = OWN_DC;
    else if (owner_q == OWN_XB && xb_req) owner_d = OWN_XB;
    else if (dc_req && xb_req)            owner_d = prio_q ? OWN_XB : OWN_DC;
    else if (dc_req)                      owner_d = OWN_DC;
    else if (xb_req)                      owner_d = OWN_XB;
    else                                  owner_d = OWN_NONE;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) owner_q <= OWN_NONE;
    else        owner_q <= owner_d;
  end

  assign dc_gnt = (owner_q == OWN_DC);
  assign xb_gnt = (owner_q == OWN_XB);

  always_comb begin
    case (mode_q)
      3'b001:  way_cnt = CNT_W'(1);
      3'b010:  way_cnt = CNT_W'(2);
      3'b011:  way_cnt = CNT_W'(3);
      3'b111:  way_cnt = CNT_W'(NUM_WAYS);
      default: way_cnt = '0;
    endcase
  end

  for (genvar w = 0; w < NUM_WAYS; w++) begin : g_way
    assign way_en[w] = (CNT_W'(w) < way_cnt);
  end

  assign sram_kb = SRAM_W'((NUM_WAYS - int'(way_cnt)) * WAY_KB);
endmodule

// File: rtl/l2_port_arbiter_chk.sv
module l2_port_arbiter_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        cfg_wr_en,
  input logic [31:0] cfg_wdata,
  input logic [31:0] cfg_rdata,
  input logic        dc_req,
  input logic        dc_gnt,
  input logic        xb_req,
  input logic        xb_gnt,
  input logic        inv_prog,
  input logic        inv_data
);
  assert_one_grant_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({dc_gnt, xb_gnt}));

  assert_dc_gnt_had_req_R8: assert property (@(posedge clk) disable iff (!rst_n)
    dc_gnt |-> $past(dc_req));

  assert_xb_gnt_had_req_R8: assert property (@(posedge clk) disable iff (!rst_n)
    xb_gnt |-> $past(xb_req));

  assert_dc_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (dc_gnt && dc_req) |=> dc_gnt);

  assert_xb_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (xb_gnt && xb_req) |=> xb_gnt);

  assert_dc_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (dc_req && xb_req && !dc_gnt && !xb_gnt && !cfg_rdata[31]) |=> dc_gnt);

  assert_xb_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (dc_req && xb_req && !dc_gnt && !xb_gnt && cfg_rdata[31]) |=> xb_gnt);

  assert_prog_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_wr_en && cfg_wdata[9]) |=> inv_prog);

  assert_data_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_wr_en && cfg_wdata[8]) |=> inv_data);

  assert_prog_cause_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !(cfg_wr_en && cfg_wdata[9]) |=> !inv_prog);

  assert_mode_legal_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_rdata[2:0] == 3'b111) || !cfg_rdata[2]);
endmodule

bind l2_port_arbiter l2_port_arbiter_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_wr_en(cfg_wr_en), .cfg_wdata(cfg_wdata),
  .cfg_rdata(cfg_rdata), .dc_req(dc_req), .dc_gnt(dc_gnt), .xb_req(xb_req),
  .xb_gnt(xb_gnt), .inv_prog(inv_prog), .inv_data(inv_data)
);

// File: tb/test_l2_port_arbiter.sv
module test_l2_port_arbiter;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        cfg_wr_en = 0;
  logic [31:0] cfg_wdata = 0;
  logic [31:0] cfg_rdata;
  logic        dc_req = 0, xb_req = 0;
  logic        dc_gnt, xb_gnt, inv_prog, inv_data;
  logic [3:0]  way_en;
  logic [6:0]  sram_kb;

  int checks = 0, errors = 0;
  bit done = 0;

  bit         e_prio, e_invp, e_invd;
  logic [2:0] e_mode;
  int         e_owner;

  always #5 clk = ~clk;

  l2_port_arbiter i_l2_port_arbiter (
    .clk(clk), .rst_n(rst_n), .cfg_wr_en(cfg_wr_en), .cfg_wdata(cfg_wdata),
    .cfg_rdata(cfg_rdata), .dc_req(dc_req), .dc_gnt(dc_gnt), .xb_req(xb_req),
    .xb_gnt(xb_gnt), .inv_prog(inv_prog), .inv_data(inv_data),
    .way_en(way_en), .sram_kb(sram_kb));

  function automatic int ways_of(input logic [2:0] m);
    case (m)
      3'b001: return 1;
      3'b010: return 2;
      3'b011: return 3;
      3'b111: return 4;
      default: return 0;
    endcase
  endfunction

  function automatic logic [3:0] mask_of(input logic [2:0] m);
    return 4'((1 << ways_of(m)) - 1);
  endfunction

  function automatic int sram_of(input logic [2:0] m);
    return 64 - 16 * ways_of(m);
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic model(input bit wr, input logic [31:0] wd, input bit dc, input bit xb);
    int nxt;
    if (e_owner == 1 && dc) nxt = 1;
    else if (e_owner == 2 && xb) nxt = 2;
    else if (dc && xb) nxt = e_prio ? 2 : 1;
    else if (dc) nxt = 1;
    else if (xb) nxt = 2;
    else nxt = 0;
    e_owner = nxt;
    e_invp = wr && wd[9];
    e_invd = wr && wd[8];
    if (wr) begin
      e_prio = wd[31];
      if (wd[2:0] == 3'b111 || !wd[2]) e_mode = wd[2:0];
    end
  endtask

  task automatic cyc(input bit wr, input logic [31:0] wd, input bit dc, input bit xb);
    cfg_wr_en = wr; cfg_wdata = wd; dc_req = dc; xb_req = xb;
    @(posedge clk);
    model(wr, wd, dc, xb);
    @(negedge clk);
    chk("R8 dc_gnt", 32'(dc_gnt), 32'(e_owner == 1));
    chk("R8 xb_gnt", 32'(xb_gnt), 32'(e_owner == 2));
    chk("R2 rdata", cfg_rdata, {e_prio, 28'd0, e_mode});
    chk("R4 inv_prog", 32'(inv_prog), 32'(e_invp));
    chk("R5 inv_data", 32'(inv_data), 32'(e_invd));
    chk("R6 way_en", 32'(way_en), 32'(mask_of(e_mode)));
    chk("R6 sram_kb", 32'(sram_kb), 32'(sram_of(e_mode)));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [2:0] legal [5] = '{3'b000, 3'b001, 3'b010, 3'b011, 3'b111};
    void'($urandom(32'd1234));
    e_prio = 0; e_mode = 0; e_invp = 0; e_invd = 0; e_owner = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1;
    // R1 reset state
    chk("R1 rdata", cfg_rdata, 32'h0);
    chk("R1 grants", 32'({dc_gnt, xb_gnt}), 32'h0);
    chk("R1 pulses", 32'({inv_prog, inv_data}), 32'h0);
    chk("R1 way_en", 32'(way_en), 32'h0);
    chk("R1 sram_kb", 32'(sram_kb), 32'd64);

    // R11 free port granted next cycle
    cyc(0, 0, 1, 0);
    chk("R11 dc granted", 32'(dc_gnt), 32'd1);
    // R10 priority flip mid-transfer does not steal the port
    cyc(1, 32'h8000_0000, 1, 1);
    chk("R10 dc held", 32'(dc_gnt), 32'd1);
    cyc(0, 0, 1, 1);
    chk("R10 dc held after flip", 32'(dc_gnt), 32'd1);
    // R11 hand-off to waiting requestor
    cyc(0, 0, 0, 1);
    chk("R11 xb handoff", 32'(xb_gnt), 32'd1);
    cyc(0, 0, 0, 0);
    // R9 contest from idle, priority 1
    cyc(0, 0, 1, 1);
    chk("R9 xb wins prio1", 32'(xb_gnt), 32'd1);
    cyc(1, 32'h0, 0, 0);
    cyc(0, 0, 1, 1);
    chk("R9 dc wins prio0", 32'(dc_gnt), 32'd1);
    cyc(0, 0, 0, 0);

    // R3 reserved bits, R4/R5 pulses
    cyc(1, 32'hFFFF_FFFF, 0, 0);
    chk("R3 rdata reserved zero", cfg_rdata, 32'h8000_0007);
    chk("R4 pulse on", 32'(inv_prog), 32'd1);
    chk("R5 pulse on", 32'(inv_data), 32'd1);
    cyc(0, 0, 0, 0);
    chk("R4 pulse single", 32'(inv_prog), 32'd0);
    chk("R5 pulse single", 32'(inv_data), 32'd0);

    // R7 reserved modes keep mode, priority still written
    for (int c = 4; c < 7; c++) begin
      cyc(1, 32'(c), 0, 0);
      chk("R7 mode kept", 32'(cfg_rdata), 32'h0000_0007);
    end
    // R6 each legal mode
    for (int i = 0; i < 5; i++) begin
      cyc(1, {29'd0, legal[i]}, 0, 0);
      chk("R6 mask", 32'(way_en), 32'(mask_of(legal[i])));
      chk("R6 sram", 32'(sram_kb), 32'(sram_of(legal[i])));
    end

    // random phase
    for (int n = 0; n < 4000; n++) begin
      bit wr, dc, xb;
      logic [31:0] wd;
      wr = ($urandom_range(0, 9) == 0);
      wd = $urandom;
      dc = (dc_req && $urandom_range(0, 7) != 0) || (!dc_req && $urandom_range(0, 2) == 0);
      xb = (xb_req && $urandom_range(0, 7) != 0) || (!xb_req && $urandom_range(0, 2) == 0);
      cyc(wr, wd, dc, xb);
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule